// File: doc/BRIEF.md
# System configuration register bank

This block holds the top-level configuration words of a graphics companion device behind a plain word-wide register bus. A host writes with `wr_en`, reads with `rd_en`, and sees one 32-bit register per aligned byte offset. The control words include system and miscellaneous control, two GPIO control words, an interrupt mask, a timing word and a power-mode selector. Each has its own mask of writable bits. The other offsets behave in one of these ways:

- The DRAM control word is special. A write to it only sets bits, and the same write also loads a 3-bit local-memory size index. A read composes the sticky bits with that index.
- Three offsets return fixed identification and status constants.
- The four power-mode gate and clock offsets take writes and discard them.
- Any other offset, including an unaligned one, raises a one-cycle error pulse and changes nothing.

The current size index leaves the block on `mem_size_idx` for the memory-mapping logic next to it. At reset it takes a value derived from the `MEM_MIB` parameter. That value is the position of the smallest size in the ordered list 4, 8, 16, 32, 64, 2 MiB that is at least `MEM_MIB`. If no entry qualifies, the index is 0.

Top module: `sysreg_bank`

## Requirements
- R1: After reset, system control (0x00) reads 0x00100000 and misc control (0x04) reads 0x00001000. GPIO low (0x08), GPIO high (0x0C), interrupt mask (0x30), timing (0x68), power mode (0x54) and the stored DRAM bits all read 0.
- R2: `rvalid` is high for exactly the cycle after each `rd_en` cycle, and `rdata` changes only then. Between reads `rdata` holds its last value.
- R3: A write to a plain register replaces its content with the written value ANDed with that register's mask. The masks are: system control 0xE300B8F7, misc control 0xFF7FFF20, timing 0xF31F1FFF, power mode 0x00000003, and 0xFFFFFFFF for GPIO low, GPIO high and interrupt mask.
- R4: A write to DRAM control (0x10) loads wdata[15:13] into the size index. The same write ORs (wdata & 0x7FFFFFC3) into the stored word, so no write ever clears a stored bit.
- R5: A read of DRAM control returns (stored & 0x07F107C0) with the size index in bits 15:13.
- R6: Offset 0x60 reads 0x050100A0, 0x38 reads 0x00021807 and 0x3C reads 0x2A1A0A09. A write to any of these three offsets raises `err` and changes nothing.
- R7: Writes to 0x40, 0x44, 0x48 and 0x4C complete without `err` and change nothing. Reads of those offsets raise `err`.
- R8: Any access to an offset not named above, or to a non-multiple of 4, raises `err` for one cycle, the cycle after the strobe. Such a read returns 0, and no state changes.
- R9: The reset size index is the position in {4,8,16,32,64,2} MiB of the smallest entry that is at least `MEM_MIB`, or 0 when none qualifies. For example, 16 gives 2, 1 gives 5 and 100 gives 0.
- R10: `mem_size_idx` always equals the current size index and changes only through DRAM control writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read strobe, one cycle per read |
| wr_en | input | 1 | Write strobe, one cycle per write |
| addr | input | ADDR_W | Byte offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| rvalid | output | 1 | High the cycle after a read strobe |
| err | output | 1 | One-cycle pulse for an access to an unimplemented offset |
| mem_size_idx | output | 3 | Current local-memory size index |

## Verification
The bench sweeps every byte address, aligned or not, with reads and with several write patterns. It compares each response against a model built from the masks and offsets listed above.

Several corner cases are targeted, each with the failure it would expose:
- **DRAM write semantics.** A DRAM word that a write replaced instead of OR-accumulating would lose bits when an all-zero pattern follows an all-ones one. An index read from the wrong bit field would show up in `mem_size_idx` and in bits 15:13 of the read.
- **Writes to read-only offsets.** Writes to constant offsets, to the discarded power-mode offsets and to unaligned addresses are each followed by full read-back. A decoder that aliased them onto real registers would corrupt a later read, and a wrong error classification shows directly on `err`.
- **Reset index.** Three instances with different memory sizes catch a size search that picks the first fitting entry rather than the smallest one.

// File: rtl/sysreg_pkg.sv
package sysreg_pkg;

  localparam int DATA_W  = 32;
  localparam int NPLAIN  = 7;
  localparam int NIGN    = 4;
  localparam int IDX_W   = 3;
  localparam int IDX_LSB = 13;

  localparam logic [7:0] OFF_DRAM     = 8'h10;
  localparam logic [7:0] OFF_DEVID    = 8'h60;
  localparam logic [7:0] OFF_GATE_NOW = 8'h38;
  localparam logic [7:0] OFF_CLK_NOW  = 8'h3C;
  localparam logic [7:0] OFF_IGN_BASE = 8'h40;

  localparam logic [DATA_W-1:0] DEVID_VAL    = 32'h050100A0;
  localparam logic [DATA_W-1:0] GATE_NOW_VAL = 32'h00021807;
  localparam logic [DATA_W-1:0] CLK_NOW_VAL  = 32'h2A1A0A09;
  localparam logic [DATA_W-1:0] DRAM_WR_MASK = 32'h7FFFFFC3;
  localparam logic [DATA_W-1:0] DRAM_RD_MASK = 32'h07F107C0;

  // Plain registers: 0 sysctl, 1 misc, 2 gpio lo, 3 gpio hi, 4 irq mask, 5 timing, 6 power mode
  function automatic logic [7:0] plain_off(int i);
    case (i)
      0:       return 8'h00;
      1:       return 8'h04;
      2:       return 8'h08;
      3:       return 8'h0C;
      4:       return 8'h30;
      5:       return 8'h68;
      default: return 8'h54;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] plain_mask(int i);
    case (i)
      0:       return 32'hE300B8F7;
      1:       return 32'hFF7FFF20;
      5:       return 32'hF31F1FFF;
      6:       return 32'h00000003;
      default: return 32'hFFFFFFFF;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] plain_rst(int i);
    case (i)
      0:       return 32'h00100000;
      1:       return 32'h00001000;
      default: return 32'h00000000;
    endcase
  endfunction

  function automatic int unsigned mem_tbl(int i);
    case (i)
      0:       return 4;
      1:       return 8;
      2:       return 16;
      3:       return 32;
      4:       return 64;
      default: return 2;
    endcase
  endfunction

  // Position of the smallest table entry not below mib; 0 if none fits
  function automatic logic [IDX_W-1:0] size_index(int unsigned mib);
    int unsigned best;
    int          pos;
    best = 0;
    pos  = 0;
    for (int i = 0; i < 6; i++) begin
      if (mem_tbl(i) >= mib && (best == 0 || best > mem_tbl(i))) begin
        best = mem_tbl(i);
        pos  = i;
      end
    end
    return IDX_W'(pos);
  endfunction

endpackage

// File: rtl/sysreg_decode.sv
module sysreg_decode
  import sysreg_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [NPLAIN-1:0] plain_sel,
  output logic              dram_sel,
  output logic              devid_sel,
  output logic              gate_sel,
  output logic              clk_sel,
  output logic              rd_ok,
  output logic              wr_ok
);

  logic [NIGN-1:0] ign_hit;

  for (genvar i = 0; i < NPLAIN; i++) begin : g_plain
    assign plain_sel[i] = (addr == ADDR_W'(plain_off(i)));
  end

  for (genvar k = 0; k < NIGN; k++) begin : g_ign
    assign ign_hit[k] = (addr == ADDR_W'(OFF_IGN_BASE + 8'(4 * k)));
  end

  assign dram_sel  = (addr == ADDR_W'(OFF_DRAM));
  assign devid_sel = (addr == ADDR_W'(OFF_DEVID));
  assign gate_sel  = (addr == ADDR_W'(OFF_GATE_NOW));
  assign clk_sel   = (addr == ADDR_W'(OFF_CLK_NOW));

  assign rd_ok = (|plain_sel) | dram_sel | devid_sel | gate_sel | clk_sel;
  assign wr_ok = (|plain_sel) | dram_sel | (|ign_hit);

endmodule

// File: rtl/sysreg_file.sv
module sysreg_file
  import sysreg_pkg::*;
#(
  parameter logic [IDX_W-1:0] IDX_RST = '0
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wr_en,
  input  logic [DATA_W-1:0]              wdata,
  input  logic [NPLAIN-1:0]              plain_sel,
  input  logic                           dram_sel,
  output logic [NPLAIN-1:0][DATA_W-1:0]  plain_q,
  output logic [DATA_W-1:0]              dram_q,
  output logic [IDX_W-1:0]               size_idx
);

  for (genvar i = 0; i < NPLAIN; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        plain_q[i] <= plain_rst(i);
      end else if (wr_en && plain_sel[i]) begin
        plain_q[i] <= wdata & plain_mask(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dram_q   <= '0;
      size_idx <= IDX_RST;
    end else if (wr_en && dram_sel) begin
      dram_q   <= dram_q | (wdata & DRAM_WR_MASK);
      size_idx <= wdata[IDX_LSB +: IDX_W];
    end
  end

endmodule

// File: rtl/sysreg_rdport.sv
module sysreg_rdport
  import sysreg_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          rd_en,
  input  logic                          wr_en,
  input  logic                          rd_ok,
  input  logic                          wr_ok,
  input  logic [NPLAIN-1:0]             plain_sel,
  input  logic                          dram_sel,
  input  logic                          devid_sel,
  input  logic                          gate_sel,
  input  logic                          clk_sel,
  input  logic [NPLAIN-1:0][DATA_W-1:0] plain_q,
  input  logic [DATA_W-1:0]             dram_q,
  input  logic [IDX_W-1:0]              size_idx,
  output logic [DATA_W-1:0]             rdata,
  output logic                          rvalid,
  output logic                          err
);

  logic [DATA_W-1:0] word;

  always_comb begin
    word = '0;
    for (int i = 0; i < NPLAIN; i++) begin
      if (plain_sel[i]) word = word | plain_q[i];
    end
    if (dram_sel)  word = word | (dram_q & DRAM_RD_MASK) | (DATA_W'(size_idx) << IDX_LSB);
    if (devid_sel) word = word | DEVID_VAL;
    if (gate_sel)  word = word | GATE_NOW_VAL;
    if (clk_sel)   word = word | CLK_NOW_VAL;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
      err    <= 1'b0;
    end else begin
      rvalid <= rd_en;
      err    <= (rd_en & ~rd_ok) | (wr_en & ~wr_ok);
      if (rd_en) rdata <= rd_ok ? word : '0;
    end
  end

endmodule

// File: rtl/sysreg_bank.sv
module sysreg_bank
  import sysreg_pkg::*;
#(
  parameter int          ADDR_W  = 8,
  parameter int unsigned MEM_MIB = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              rvalid,
  output logic              err,
  output logic [2:0]        mem_size_idx
);

  localparam logic [IDX_W-1:0] IDX_RST = size_index(MEM_MIB);

  logic [NPLAIN-1:0]             plain_sel;
  logic                          dram_sel, devid_sel, gate_sel, clk_sel;
  logic                          rd_ok, wr_ok;
  logic [NPLAIN-1:0][DATA_W-1:0] plain_q;
  logic [DATA_W-1:0]             dram_q;
  logic [IDX_W-1:0]              size_idx;

  sysreg_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr      (addr),
    .plain_sel (plain_sel),
    .dram_sel  (dram_sel),
    .devid_sel (devid_sel),
    .gate_sel  (gate_sel),
    .clk_sel   (clk_sel),
    .rd_ok     (rd_ok),
    .wr_ok     (wr_ok)
  );

  sysreg_file #(.IDX_RST(IDX_RST)) u_file (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wdata     (wdata),
    .plain_sel (plain_sel),
    .dram_sel  (dram_sel),
    .plain_q   (plain_q),
    .dram_q    (dram_q),
    .size_idx  (size_idx)
  );

  sysreg_rdport u_rd (
    .clk       (clk),
    .rst       (rst),
    .rd_en     (rd_en),
    .wr_en     (wr_en),
    .rd_ok     (rd_ok),
    .wr_ok     (wr_ok),
    .plain_sel (plain_sel),
    .dram_sel  (dram_sel),
    .devid_sel (devid_sel),
    .gate_sel  (gate_sel),
    .clk_sel   (clk_sel),
    .plain_q   (plain_q),
    .dram_q    (dram_q),
    .size_idx  (size_idx),
    .rdata     (rdata),
    .rvalid    (rvalid),
    .err       (err)
  );

  assign mem_size_idx = size_idx;

endmodule

// File: rtl/sysreg_bank_chk.sv
module sysreg_bank_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_en,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       rdata,
  input logic              rvalid,
  input logic              err,
  input logic [2:0]        mem_size_idx
);

  // R2
  rd_valid_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rvalid);

  // R2
  valid_src_chk: assert property (@(posedge clk) disable iff (rst)
    rvalid |-> $past(rd_en));

  // R2
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));

  // R8
  err_src_chk: assert property (@(posedge clk) disable iff (rst)
    err |-> $past(rd_en || wr_en));

  // R8
  err_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rvalid && err) |-> (rdata == 32'h0));

  // R10
  idx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(mem_size_idx));

  // R6
  devid_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !wr_en && addr == ADDR_W'(8'h60)) |=> (rdata == 32'h050100A0 && !err));

  // R3
  pwr_bits_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == ADDR_W'(8'h54)) |=> (rdata[31:2] == 30'h0));

  // R5
  dram_rd_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !wr_en && addr == ADDR_W'(8'h10)) |=>
      (rdata[15:13] == mem_size_idx && (rdata & ~32'h07F1E7C0) == 32'h0));

endmodule

bind sysreg_bank sysreg_bank_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .rd_en        (rd_en),
  .wr_en        (wr_en),
  .addr         (addr),
  .rdata        (rdata),
  .rvalid       (rvalid),
  .err          (err),
  .mem_size_idx (mem_size_idx)
);

// File: tb/test_sysreg_bank.sv
module test_sysreg_bank;
  timeunit 1ns;
  timeprecision 100ps;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rd_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, rdata_s, rdata_l;
  logic        rvalid, rvalid_s, rvalid_l;
  logic        err, err_s, err_l;
  logic [2:0]  idx, idx_s, idx_l;

  always #2.5 clk = ~clk;

  sysreg_bank #(.ADDR_W(8), .MEM_MIB(16)) i_sysreg_bank (
    .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .rvalid(rvalid), .err(err), .mem_size_idx(idx));
  sysreg_bank #(.ADDR_W(8), .MEM_MIB(1)) i_sysreg_bank_small (
    .clk(clk), .rst(rst), .rd_en(1'b0), .wr_en(1'b0), .addr(addr), .wdata(wdata),
    .rdata(rdata_s), .rvalid(rvalid_s), .err(err_s), .mem_size_idx(idx_s));
  sysreg_bank #(.ADDR_W(8), .MEM_MIB(100)) i_sysreg_bank_large (
    .clk(clk), .rst(rst), .rd_en(1'b0), .wr_en(1'b0), .addr(addr), .wdata(wdata),
    .rdata(rdata_l), .rvalid(rvalid_l), .err(err_l), .mem_size_idx(idx_l));

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] m_plain [7];
  logic [31:0] m_dram;
  logic [2:0]  m_idx;

  function automatic int pidx(logic [7:0] a);
    case (a)
      8'h00: return 0;
      8'h04: return 1;
      8'h08: return 2;
      8'h0C: return 3;
      8'h30: return 4;
      8'h68: return 5;
      8'h54: return 6;
      default: return -1;
    endcase
  endfunction

  function automatic logic [31:0] pmask(int i);
    case (i)
      0: return 32'hE300B8F7;
      1: return 32'hFF7FFF20;
      5: return 32'hF31F1FFF;
      6: return 32'h00000003;
      default: return 32'hFFFFFFFF;
    endcase
  endfunction

  function automatic bit is_const(logic [7:0] a);
    return a == 8'h60 || a == 8'h38 || a == 8'h3C;
  endfunction

  function automatic bit is_ign(logic [7:0] a);
    return a == 8'h40 || a == 8'h44 || a == 8'h48 || a == 8'h4C;
  endfunction

  function automatic bit wr_ok(logic [7:0] a);
    return pidx(a) >= 0 || a == 8'h10 || is_ign(a);
  endfunction

  function automatic bit rd_ok(logic [7:0] a);
    return pidx(a) >= 0 || a == 8'h10 || is_const(a);
  endfunction

  function automatic logic [31:0] exp_rd(logic [7:0] a);
    if (pidx(a) >= 0) return m_plain[pidx(a)];
    if (a == 8'h10) return (m_dram & 32'h07F107C0) | {16'h0, m_idx, 13'h0};
    if (a == 8'h60) return 32'h050100A0;
    if (a == 8'h38) return 32'h00021807;
    if (a == 8'h3C) return 32'h2A1A0A09;
    return 32'h0;
  endfunction

  function automatic string req_of(logic [7:0] a);
    if (pidx(a) >= 0) return "R3";
    if (a == 8'h10) return "R5";
    if (is_const(a)) return "R6";
    if (is_ign(a)) return "R7";
    return "R8";
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 7; i++) m_plain[i] = 32'h0;
    m_plain[0] = 32'h00100000;
    m_plain[1] = 32'h00001000;
    m_dram = 32'h0;
    m_idx  = 3'd2;
  endtask

  task automatic do_write(logic [7:0] a, logic [31:0] v);
    string rq;
    @(negedge clk);
    addr = a; wdata = v; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    if (pidx(a) >= 0) m_plain[pidx(a)] = v & pmask(pidx(a));
    if (a == 8'h10) begin
      m_idx  = v[15:13];
      m_dram = m_dram | (v & 32'h7FFFFFC3);
    end
    rq = (a == 8'h10) ? "R4" : req_of(a);
    chk(err == !wr_ok(a), rq, {31'h0, err}, {31'h0, !wr_ok(a)});
    chk(idx == m_idx, "R10", {29'h0, idx}, {29'h0, m_idx});
  endtask

  task automatic do_read(logic [7:0] a, string rq);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    chk(rvalid == 1'b1, "R2", {31'h0, rvalid}, 32'h1);
    chk(err == !rd_ok(a), rq, {31'h0, err}, {31'h0, !rd_ok(a)});
    chk(rdata == exp_rd(a), rq, rdata, exp_rd(a));
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      finish_run();
    end
  end

  logic [31:0] pats [5] = '{32'h00000000, 32'h5A5AA5A5, 32'hFFFFFFFF, 32'h00000000, 32'h13572468};

  initial begin
    model_reset();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(rvalid == 1'b0 && err == 1'b0, "R1", {30'h0, rvalid, err}, 32'h0);
    chk(idx == 3'd2, "R9", {29'h0, idx}, 32'd2);
    chk(idx_s == 3'd5, "R9", {29'h0, idx_s}, 32'd5);
    chk(idx_l == 3'd0, "R9", {29'h0, idx_l}, 32'd0);

    // R1 reset contents over every byte address
    for (int a = 0; a < 256; a++) do_read(8'(a), (pidx(8'(a)) >= 0 || a == 16) ? "R1" : req_of(8'(a)));

    // R2 hold between reads
    do_read(8'h60, "R6");
    @(negedge clk);
    chk(rvalid == 1'b0, "R2", {31'h0, rvalid}, 32'h0);
    chk(rdata == 32'h050100A0, "R2", rdata, 32'h050100A0);

    // R3 R4 R6 R7 R8 write sweeps with read-back
    for (int p = 0; p < 5; p++) begin
      for (int a = 0; a < 256; a++) do_write(8'(a), pats[p] ^ {4{8'(a)}});
      for (int a = 0; a < 256; a++) do_read(8'(a), req_of(8'(a)));
    end

    // R4 sticky bits survive an all-zero write
    do_write(8'h10, 32'hFFFFFFFF);
    do_write(8'h10, 32'h00000000);
    do_read(8'h10, "R4");
    chk(idx == 3'd0, "R10", {29'h0, idx}, 32'd0);
    do_write(8'h10, 32'h0000A000);
    chk(idx == 3'd5, "R4", {29'h0, idx}, 32'd5);
    do_read(8'h10, "R5");

    done = 1;
    finish_run();
  end

endmodule